// File: doc/BRIEF.md
# Hyperdimensional Trigram Text Classifier

The block reads a stream of text symbols and gives each one a fixed pseudo-random binary hypervector. Every window of three consecutive symbols becomes a trigram vector. The oldest symbol's vector is rotated twice and the middle one's once, and the three are combined by XOR. All trigrams of a text are merged by bitwise OR into one map vector.

Each text ends with an end-of-text strobe. In training mode that strobe stores the map as the vector of the selected class, in one shot, replacing whatever was there. In inference mode the map becomes a query. The block then compares it with every class vector by Hamming distance, one class per cycle. It reports the nearest class and its distance with a single-cycle valid pulse.

Symbols enter with a valid/ready handshake. Ready is low during a search and during the strobe cycle.

Top module: `hdc_trigram_classifier`

## Requirements
- R1: Symbol codes 0..25 are the letters a..z and 26 is space; codes 27..31 behave exactly like 26. For symbol s the vector is built in 32-bit words. Start from x = (s+1)*32'h9E3779B9, truncated to 32 bits. Word k (bits 32k+31..32k) is x after k+1 steps of x^=x<<13, x^=x>>17, x^=x<<5.
- R2: Let rot1(v) be a one-bit left rotation ({v[W-2:0],v[W-1]}) and rot2 two such rotations. For an accepted symbol c(t) with two earlier symbols since the last strobe, the trigram is rot2(item[c(t-2)]) ^ rot1(item[c(t-1)]) ^ item[c(t)].
- R3: The first two symbols after reset or after an accepted strobe produce no trigram. An accepted strobe clears the symbol history and the map.
- R4: The map is the bitwise OR of all trigrams of the current text. A text with no trigram has an all-zero map.
- R5: A training strobe (mode_i=0) overwrites the vector of class class_i with the map and gives no result pulse.
- R6: An inference strobe (mode_i=1) accepted at edge E gives res_valid_o high for exactly one cycle. The pulse follows the NUM_CLASSES-th rising edge after E and carries the nearest class and its Hamming distance.
- R7: When several classes share the smallest distance, the lowest class index is reported.
- R8: char_ready_o is low while eot_i is high and while a search runs. A strobe that arrives during a search is ignored.
- R9: After reset all class vectors are zero, res_valid_o is 0 and char_ready_o is 1.
- R10: The distance to a class that holds an all-zero vector equals the number of ones in the query map.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| char_valid_i | input | 1 | Symbol offered |
| char_i | input | 5 | Symbol code |
| char_ready_o | output | 1 | Symbol accepted when high with char_valid_i |
| mode_i | input | 1 | 0 = training, 1 = inference |
| class_i | input | CW | Class written on a training strobe |
| eot_i | input | 1 | End-of-text strobe |
| res_valid_o | output | 1 | One-cycle result pulse |
| res_class_o | output | CW | Nearest class index |
| res_dist_o | output | DW | Hamming distance to that class |

## Verification
Queries identical to trained texts must return distance 0 at their own class. These show that storage, encoding and search agree without needing a model. Queries that are perfect, partial or single-trigram matches are also compared against an independent model of the item vectors and the rotation. Those cases separate rotation direction, binding and OR bundling errors.

Two-symbol texts (an empty map), repeated class contents and a query taken before any training probe the warm-up rule, the tie order and the zero-vector distance. Symbol codes above 26 check the space alias. A strobe issued during a running search checks that it is ignored.

// File: rtl/hdc_pkg.sv
package hdc_pkg;
  localparam int SYM_W = 5;
  localparam logic [SYM_W-1:0] SYM_SPACE = 5'd26;
  localparam logic [31:0] SEED_MUL = 32'h9E3779B9;

  typedef enum logic {MODE_TRAIN = 1'b0, MODE_INFER = 1'b1} hdc_mode_e;

  function automatic logic [31:0] xs_step(input logic [31:0] v);
    logic [31:0] r;
    r = v ^ (v << 13);
    r = r ^ (r >> 17);
    r = r ^ (r << 5);
    return r;
  endfunction
endpackage

// File: rtl/hdc_item_mem.sv
module hdc_item_mem
  import hdc_pkg::*;
#(
  parameter int HV_W = 1024,
  localparam int NWORD = HV_W / 32
) (
  input  logic [SYM_W-1:0] sym_i,
  output logic [HV_W-1:0]  vec_o
);
  logic [SYM_W-1:0] sym_eff;
  logic [31:0]      x;

  always_comb begin
    sym_eff = (sym_i > SYM_SPACE) ? SYM_SPACE : sym_i;
    x = ({27'd0, sym_eff} + 32'd1) * SEED_MUL;
    vec_o = '0;
    for (int k = 0; k < NWORD; k++) begin
      x = xs_step(x);
      vec_o[32*k +: 32] = x;
    end
  end
endmodule

// File: rtl/hdc_encoder.sv
module hdc_encoder #(
  parameter int HV_W = 1024
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            push_i,
  input  logic            clear_i,
  input  logic [HV_W-1:0] item_i,
  output logic [HV_W-1:0] bundle_o
);
  logic [HV_W-1:0] h1_q, h2_q, acc_q, tri_w;
  logic [1:0]      cnt_q;

  assign tri_w = {h2_q[HV_W-3:0], h2_q[HV_W-1:HV_W-2]}
               ^ {h1_q[HV_W-2:0], h1_q[HV_W-1]}
               ^ item_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h1_q  <= '0;
      h2_q  <= '0;
      acc_q <= '0;
      cnt_q <= '0;
    end else if (clear_i) begin
      h1_q  <= '0;
      h2_q  <= '0;
      acc_q <= '0;
      cnt_q <= '0;
    end else if (push_i) begin
      h2_q <= h1_q;
      h1_q <= item_i;
      if (cnt_q == 2'd2) acc_q <= acc_q | tri_w;
      else cnt_q <= cnt_q + 2'd1;
    end
  end

  assign bundle_o = acc_q;
endmodule

// File: rtl/hdc_search.sv
module hdc_search #(
  parameter int HV_W = 1024,
  parameter int NUM_CLASSES = 4,
  localparam int CW = (NUM_CLASSES > 1) ? $clog2(NUM_CLASSES) : 1,
  localparam int DW = $clog2(HV_W + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            store_i,
  input  logic            start_i,
  input  logic [CW-1:0]   class_i,
  input  logic [HV_W-1:0] bundle_i,
  output logic            busy_o,
  output logic            res_valid_o,
  output logic [CW-1:0]   res_class_o,
  output logic [DW-1:0]   res_dist_o
);
  logic [HV_W-1:0] maps_q [NUM_CLASSES];
  logic [HV_W-1:0] query_q;
  logic [CW-1:0]   idx_q, best_q;
  logic [DW-1:0]   bestd_q, dist_w;
  logic            better_w, last_w;

  function automatic logic [DW-1:0] popcnt(input logic [HV_W-1:0] v);
    logic [DW-1:0] n;
    n = '0;
    for (int i = 0; i < HV_W; i++) n = n + DW'(v[i]);
    return n;
  endfunction

  assign dist_w   = popcnt(query_q ^ maps_q[idx_q]);
  assign better_w = dist_w < bestd_q;  // strict: ties keep lower index
  assign last_w   = idx_q == CW'(NUM_CLASSES - 1);

  genvar g;
  generate
    for (g = 0; g < NUM_CLASSES; g++) begin : g_map
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) maps_q[g] <= '0;
        else if (store_i && class_i == CW'(g)) maps_q[g] <= bundle_i;
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      query_q     <= '0;
      idx_q       <= '0;
      best_q      <= '0;
      bestd_q     <= '1;
      busy_o      <= 1'b0;
      res_valid_o <= 1'b0;
      res_class_o <= '0;
      res_dist_o  <= '0;
    end else begin
      res_valid_o <= 1'b0;
      if (start_i) begin
        query_q <= bundle_i;
        idx_q   <= '0;
        best_q  <= '0;
        bestd_q <= '1;
        busy_o  <= 1'b1;
      end else if (busy_o) begin
        if (better_w) begin
          best_q  <= idx_q;
          bestd_q <= dist_w;
        end
        idx_q <= idx_q + CW'(1);
        if (last_w) begin
          busy_o      <= 1'b0;
          res_valid_o <= 1'b1;
          res_class_o <= better_w ? idx_q : best_q;
          res_dist_o  <= better_w ? dist_w : bestd_q;
        end
      end
    end
  end
endmodule

// File: rtl/hdc_trigram_classifier.sv
module hdc_trigram_classifier
  import hdc_pkg::*;
#(
  parameter int HV_W = 1024,
  parameter int NUM_CLASSES = 4,
  localparam int CW = (NUM_CLASSES > 1) ? $clog2(NUM_CLASSES) : 1,
  localparam int DW = $clog2(HV_W + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             char_valid_i,
  input  logic [SYM_W-1:0] char_i,
  output logic             char_ready_o,
  input  logic             mode_i,
  input  logic [CW-1:0]    class_i,
  input  logic             eot_i,
  output logic             res_valid_o,
  output logic [CW-1:0]    res_class_o,
  output logic [DW-1:0]    res_dist_o
);
  logic            search_busy, push, clear, store, start;
  logic [HV_W-1:0] item, bundle;

  assign char_ready_o = !search_busy && !eot_i;
  assign push  = char_valid_i && char_ready_o;
  assign clear = eot_i && !search_busy;
  assign store = clear && (mode_i == 1'(MODE_TRAIN));
  assign start = clear && (mode_i == 1'(MODE_INFER));

  hdc_item_mem #(.HV_W(HV_W)) u_item (
    .sym_i (char_i),
    .vec_o (item)
  );

  hdc_encoder #(.HV_W(HV_W)) u_enc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .push_i   (push),
    .clear_i  (clear),
    .item_i   (item),
    .bundle_o (bundle)
  );

  hdc_search #(.HV_W(HV_W), .NUM_CLASSES(NUM_CLASSES)) u_search (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .store_i     (store),
    .start_i     (start),
    .class_i     (class_i),
    .bundle_i    (bundle),
    .busy_o      (search_busy),
    .res_valid_o (res_valid_o),
    .res_class_o (res_class_o),
    .res_dist_o  (res_dist_o)
  );
endmodule

// File: rtl/hdc_trigram_classifier_chk.sv
module hdc_trigram_classifier_chk #(
  parameter int HV_W = 1024,
  parameter int NUM_CLASSES = 4,
  localparam int CW = (NUM_CLASSES > 1) ? $clog2(NUM_CLASSES) : 1,
  localparam int DW = $clog2(HV_W + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          eot_i,
  input logic          mode_i,
  input logic          char_ready_o,
  input logic          search_busy,
  input logic          res_valid_o,
  input logic [CW-1:0] res_class_o,
  input logic [DW-1:0] res_dist_o
);
  AST_PULSE_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |=> !res_valid_o);  // R6
  AST_START_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eot_i && mode_i && !search_busy) |=> search_busy);  // R6
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> !search_busy);  // R6
  AST_TRAIN_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eot_i && !mode_i && !search_busy) |=> !res_valid_o);  // R5
  AST_EOT_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eot_i |-> !char_ready_o);  // R8
  AST_BUSY_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    search_busy |-> !char_ready_o);  // R8
  AST_CLASS_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> (32'(res_class_o) < NUM_CLASSES));  // R7
  AST_DIST_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> (32'(res_dist_o) <= HV_W));  // R10
endmodule

bind hdc_trigram_classifier hdc_trigram_classifier_chk #(
  .HV_W(HV_W), .NUM_CLASSES(NUM_CLASSES)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .eot_i        (eot_i),
  .mode_i       (mode_i),
  .char_ready_o (char_ready_o),
  .search_busy  (search_busy),
  .res_valid_o  (res_valid_o),
  .res_class_o  (res_class_o),
  .res_dist_o   (res_dist_o)
);

// File: tb/sim_hdc_trigram_classifier.sv
`timescale 1ns/1ps
module sim_hdc_trigram_classifier;
  localparam int W  = 1024;
  localparam int NC = 4;
  localparam int DW = $clog2(W + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic char_valid = 1'b0, mode = 1'b0, eot = 1'b0;
  logic [4:0] chr = '0;
  logic [1:0] cls = '0;
  logic char_ready, res_valid;
  logic [1:0] res_class;
  logic [DW-1:0] res_dist;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  hdc_trigram_classifier #(.HV_W(W), .NUM_CLASSES(NC)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .char_valid_i(char_valid), .char_i(chr),
    .char_ready_o(char_ready), .mode_i(mode), .class_i(cls), .eot_i(eot),
    .res_valid_o(res_valid), .res_class_o(res_class), .res_dist_o(res_dist)
  );

  // {mode, class, 5-char text}; inference rows expect their class at distance 0
  localparam logic [42:0] TBL [8] = '{
    {1'b0, 2'd0, "hello"}, {1'b0, 2'd1, "world"},
    {1'b0, 2'd2, "quick"}, {1'b0, 2'd3, "zebra"},
    {1'b1, 2'd2, "quick"}, {1'b1, 2'd0, "hello"},
    {1'b1, 2'd3, "zebra"}, {1'b1, 2'd1, "world"}
  };

  logic [W-1:0] mmap [NC];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int sym_of(input byte c);
    if (c == " ") return 26;
    if (c == "_") return 31;
    return int'(c) - 97;
  endfunction

  function automatic logic [W-1:0] item_m(input int s);
    logic [31:0] x;
    logic [W-1:0] v;
    int e;
    e = (s > 26) ? 26 : s;
    x = 32'(e + 1) * 32'h9E3779B9;
    for (int k = 0; k < W / 32; k++) begin
      x = x ^ (x << 13);
      x = x ^ (x >> 17);
      x = x ^ (x << 5);
      v[32*k +: 32] = x;
    end
    return v;
  endfunction

  function automatic logic [W-1:0] rl(input logic [W-1:0] v);
    return {v[W-2:0], v[W-1]};
  endfunction

  function automatic logic [W-1:0] model_map(input string s);
    logic [W-1:0] a, p1, p2, cur;
    a = '0; p1 = '0; p2 = '0;
    for (int i = 0; i < s.len(); i++) begin
      cur = item_m(sym_of(s[i]));
      if (i >= 2) a = a | (rl(rl(p2)) ^ rl(p1) ^ cur);
      p2 = p1;
      p1 = cur;
    end
    return a;
  endfunction

  function automatic int pc(input logic [W-1:0] v);
    int n = 0;
    for (int i = 0; i < W; i++) n += int'(v[i]);
    return n;
  endfunction

  task automatic feed(input string s);
    for (int i = 0; i < s.len(); i++) begin
      @(negedge clk);
      char_valid = 1'b1;
      chr = 5'(sym_of(s[i]));
      #1;
      chk(char_ready == 1'b1, "R8", "ready while idle", char_ready, 1);
      @(posedge clk);
    end
    @(negedge clk);
    char_valid = 1'b0;
  endtask

  task automatic train(input string s, input int c);
    int seen = 0;
    feed(s);
    @(negedge clk);
    mode = 1'b0; cls = 2'(c); eot = 1'b1;
    @(posedge clk);
    @(negedge clk);
    eot = 1'b0;
    mmap[c] = model_map(s);
    for (int k = 0; k < 6; k++) begin
      @(posedge clk); #1;
      if (res_valid) seen++;
    end
    chk(seen == 0, "R5", "no pulse after training strobe", seen, 0);
  endtask

  // exp_c < 0: expected result from the model of stored maps
  task automatic infer(input string s, input int exp_c, input int exp_d,
                       input string req, input bit poke_busy);
    int pulses = 0, at = -1, gc = -1, gd = -1, bc, bd;
    logic [W-1:0] q;
    q = model_map(s);
    bc = 0; bd = W + 1;
    for (int k = 0; k < NC; k++)
      if (pc(q ^ mmap[k]) < bd) begin bd = pc(q ^ mmap[k]); bc = k; end
    if (exp_c < 0) begin exp_c = bc; exp_d = bd; end
    feed(s);
    @(negedge clk);
    mode = 1'b1; eot = 1'b1;
    @(posedge clk);
    @(negedge clk);
    eot = 1'b0;
    if (poke_busy) begin
      mode = 1'b0; cls = 2'd0; eot = 1'b1;
    end
    for (int c = 1; c <= 8; c++) begin
      @(posedge clk); #1;
      if (c == 1) chk(char_ready == 1'b0, "R8", "ready low in search", char_ready, 0);
      if (poke_busy && c == 1) begin
        @(negedge clk);
        eot = 1'b0;
        mode = 1'b1;
      end
      if (res_valid) begin
        pulses++;
        if (at < 0) begin at = c; gc = res_class; gd = res_dist; end
      end
    end
    chk(pulses == 1, "R6", "pulse count", pulses, 1);
    chk(at == NC, "R6", "pulse cycle", at, NC);
    chk(gc == exp_c, req, {"class for ", s}, gc, exp_c);
    chk(gd == exp_d, req, {"distance for ", s}, gd, exp_d);
  endtask

  initial begin
    #(8 * 150000);
    chk(1'b0, "R6", "watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int k = 0; k < NC; k++) mmap[k] = '0;
    #20;
    chk(char_ready == 1'b1, "R9", "ready in reset", char_ready, 1);
    chk(res_valid == 1'b0, "R9", "valid in reset", res_valid, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(char_ready == 1'b1, "R9", "ready after reset", char_ready, 1);

    // R10 / R7: all maps zero, tie across all classes -> class 0
    infer("abc", 0, pc(model_map("abc")), "R10", 1'b0);

    // table walk: one-shot training then exact-match queries (R5, R6)
    for (int i = 0; i < 8; i++) begin
      string t;
      t = $sformatf("%s", TBL[i][39:0]);
      if (TBL[i][42]) infer(t, int'(TBL[i][41:40]), 0, "R5", 1'b0);
      else train(t, int'(TBL[i][41:40]));
    end

    // encoding checked against the item/rotation/OR model (R1, R2, R4)
    infer("helps", -1, 0, "R2", 1'b0);
    infer("wor", -1, 0, "R4", 1'b0);
    infer("zebra quick", -1, 0, "R1", 1'b0);

    // strobe during search must not overwrite class 0 (R8)
    infer("hello", 0, 0, "R8", 1'b1);
    infer("hello", 0, 0, "R8", 1'b0);

    // tie: class 3 copies class 1 -> lower index wins (R7)
    train("world", 3);
    infer("world", 1, 0, "R7", 1'b0);

    // two symbols give an empty map (R3)
    train("qq", 2);
    infer("zz", 2, 0, "R3", 1'b0);
    infer("xyz", -1, 0, "R3", 1'b0);

    // codes above 26 act as space (R1)
    train("a_b_c", 3);
    infer("a b c", 3, 0, "R1", 1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule